// File: doc/BRIEF.md
# Ethernet Transmit Collision Retry Controller

This block governs the fate of each frame handed to a 10 Mb/s half-duplex Ethernet transmitter once collisions enter the picture. A frame begins with a start strobe. From that point the block counts bit-time ticks from the first preamble bit of the current attempt. When a collision arrives, it decides whether the collision fell inside the slot window or after it.

A collision inside the window sends the block into a backoff wait. It restarts the attempt from the preamble once the external backoff timer reports completion, and no host action is needed. A collision after the window abandons the frame with a late-collision flag. A frame that collides early on every one of its allowed attempts is abandoned with a retry-exhausted flag.

Every finished frame, good or bad, produces a one-cycle status pulse that also releases ownership of the current descriptor. After a failure, the block clears ownership of each following buffer descriptor. It stops at the next descriptor that begins a new frame. While the slot window is still open, a hold output tells the data store to keep the frame's leading bytes for a possible retry.

Top module: `txCollisionRetry`

## Requirements
- R1: After reset, txActive, holdData, statusValid, ownRelease, every status flag, restartTx and skipClear are 0, and attemptCnt is 0.
- R2: In the idle state, a txStart pulse makes txActive 1 from the next cycle on, with attemptCnt equal to 1.
- R3: A collision seen while fewer than SLOT_BITS (default 512) bit ticks of the current attempt have been counted, on an attempt below MAX_ATTEMPTS, produces no status. txActive drops and the block waits for backoffDone. backoffDone raises restartTx in the same cycle, and from the next cycle txActive is 1 and attemptCnt is one higher.
- R4: holdData is 1 while txActive is 1 and fewer than SLOT_BITS ticks of the current attempt have been counted, and 0 otherwise.
- R5: A collision after at least SLOT_BITS ticks of the current attempt ends the frame with statusLateCol, and there is no retry.
- R6: An early collision on attempt number MAX_ATTEMPTS (default 16) ends the frame with statusRetryErr, and there is no further retry.
- R7: txDone during an attempt with no collision in the same cycle ends the frame with statusOk and returns to idle.
- R8: A frame ends with statusValid and ownRelease both 1 for exactly one cycle, the cycle after the ending event. In that cycle exactly one of statusOk, statusRetryErr and statusLateCol is 1. Outside that cycle all three are 0.
- R9: After a failed frame, each descStrobe with descSop 0 raises skipClear in the same cycle. A descStrobe with descSop 1 raises no skipClear and returns the block to idle. txStart has no effect while skipping.
- R10: When collision and txDone arrive in the same cycle, the collision decides the outcome.
- R11: txStart has no effect while a frame is in progress, and backoffDone has no effect outside the backoff wait.
- R12: Every new frame starts its attempt count again at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txStart | input | 1 | Begin a new frame (first preamble bit) |
| bitTick | input | 1 | One network bit time elapsed |
| collision | input | 1 | Collision detected |
| txDone | input | 1 | Current attempt finished sending |
| backoffDone | input | 1 | Backoff timer expired |
| descStrobe | input | 1 | A follow-on buffer descriptor is presented |
| descSop | input | 1 | Presented descriptor starts a new frame |
| txActive | output | 1 | An attempt is on the wire |
| restartTx | output | 1 | Restart the attempt from the preamble (combinational) |
| holdData | output | 1 | Keep frame data for a possible retry |
| attemptCnt | output | $clog2(MAX_ATTEMPTS+1) | Number of the current attempt |
| statusValid | output | 1 | Final status is present this cycle |
| statusOk | output | 1 | Frame sent successfully |
| statusRetryErr | output | 1 | All attempts ended in early collisions |
| statusLateCol | output | 1 | Collision after the slot window |
| ownRelease | output | 1 | Clear ownership of the current descriptor |
| skipClear | output | 1 | Clear ownership of the presented follow-on descriptor (combinational) |

## Verification
Frames are driven with zero to sixteen early collisions at random tick counts, followed by a clean finish or a late collision. Each run separates the plain success path, the retry path and the exhaustion path. Two directed boundary frames collide at SLOT_BITS-1 and at exactly SLOT_BITS counted ticks, which pins down where early ends and late begins. Further directed frames present collision together with txDone, stray txStart and backoffDone pulses, and skip runs of varying length that end on a start-of-packet descriptor. These check priority, the inputs that must be ignored, and where the descriptor skipping stops.

// File: rtl/txRetryPkg.sv
package txRetryPkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_XMIT    = 2'd1,
    ST_BACKOFF = 2'd2,
    ST_SKIP    = 2'd3
  } txState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic startFrame;
    logic restartAttempt;
    logic finishOk;
    logic finishRetry;
    logic finishLate;
  } ctlStrobe_t;
endpackage

// File: rtl/txRetryCtrl.sv
module txRetryCtrl
  import txRetryPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txStart,
  input  logic       collision,
  input  logic       txDone,
  input  logic       backoffDone,
  input  logic       descStrobe,
  input  logic       descSop,
  input  logic       slotOver,
  input  logic       lastAttempt,
  output ctlStrobe_t stb,
  output logic       txActive,
  output logic       skipClear
);
  txState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    skipClear = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (txStart) begin
          stb.startFrame = 1'b1;
          stateNext      = ST_XMIT;
        end
      end
      ST_XMIT: begin
        // a collision outranks a simultaneous done
        if (collision) begin
          if (slotOver) begin
            stb.finishLate = 1'b1;
            stateNext      = ST_SKIP;
          end else if (lastAttempt) begin
            stb.finishRetry = 1'b1;
            stateNext       = ST_SKIP;
          end else begin
            stateNext = ST_BACKOFF;
          end
        end else if (txDone) begin
          stb.finishOk = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      ST_BACKOFF: begin
        if (backoffDone) begin
          stb.restartAttempt = 1'b1;
          stateNext          = ST_XMIT;
        end
      end
      ST_SKIP: begin
        if (descStrobe) begin
          if (descSop) stateNext = ST_IDLE;
          else         skipClear = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign txActive = (state == ST_XMIT);
endmodule

// File: rtl/txRetryDp.sv
module txRetryDp
  import txRetryPkg::*;
#(
  parameter int SLOT_BITS    = 512,
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 bitTick,
  input  logic                                 txActive,
  input  ctlStrobe_t                           stb,
  output logic                                 slotOver,
  output logic                                 lastAttempt,
  output logic                                 holdData,
  output logic [$clog2(MAX_ATTEMPTS+1)-1:0]    attemptCnt,
  output logic                                 statusValid,
  output logic                                 statusOk,
  output logic                                 statusRetryErr,
  output logic                                 statusLateCol,
  output logic                                 ownRelease
);
  localparam int SLOT_W = $clog2(SLOT_BITS + 1);
  localparam int ATT_W  = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(SLOT_BITS);
  localparam logic [ATT_W-1:0]  ATT_LIM  = ATT_W'(MAX_ATTEMPTS);

  logic [SLOT_W-1:0] slotCnt;
  logic              anyFinish;

  // bit times since first preamble bit, saturating at the slot limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (stb.startFrame || stb.restartAttempt) begin
      slotCnt <= '0;
    end else if (txActive && bitTick && !slotOver) begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  attemptCnt <= '0;
    else if (stb.startFrame)    attemptCnt <= ATT_W'(1);
    else if (stb.restartAttempt) attemptCnt <= attemptCnt + 1'b1;
  end

  assign anyFinish = stb.finishOk | stb.finishRetry | stb.finishLate;

  // status lives for exactly the cycle after the ending event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusValid    <= 1'b0;
      ownRelease     <= 1'b0;
      statusOk       <= 1'b0;
      statusRetryErr <= 1'b0;
      statusLateCol  <= 1'b0;
    end else begin
      statusValid    <= anyFinish;
      ownRelease     <= anyFinish;
      statusOk       <= stb.finishOk;
      statusRetryErr <= stb.finishRetry;
      statusLateCol  <= stb.finishLate;
    end
  end

  assign slotOver    = (slotCnt >= SLOT_LIM);
  assign lastAttempt = (attemptCnt >= ATT_LIM);
  assign holdData    = txActive && !slotOver;
endmodule

// File: rtl/txCollisionRetry.sv
module txCollisionRetry
  import txRetryPkg::*;
#(
  parameter int SLOT_BITS    = 512,
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              txStart,
  input  logic                              bitTick,
  input  logic                              collision,
  input  logic                              txDone,
  input  logic                              backoffDone,
  input  logic                              descStrobe,
  input  logic                              descSop,
  output logic                              txActive,
  output logic                              restartTx,
  output logic                              holdData,
  output logic [$clog2(MAX_ATTEMPTS+1)-1:0] attemptCnt,
  output logic                              statusValid,
  output logic                              statusOk,
  output logic                              statusRetryErr,
  output logic                              statusLateCol,
  output logic                              ownRelease,
  output logic                              skipClear
);
  ctlStrobe_t stb;
  logic       slotOver;
  logic       lastAttempt;

  txRetryCtrl ctrlI (
    .clk         (clk),
    .rstN        (rstN),
    .txStart     (txStart),
    .collision   (collision),
    .txDone      (txDone),
    .backoffDone (backoffDone),
    .descStrobe  (descStrobe),
    .descSop     (descSop),
    .slotOver    (slotOver),
    .lastAttempt (lastAttempt),
    .stb         (stb),
    .txActive    (txActive),
    .skipClear   (skipClear)
  );

  txRetryDp #(
    .SLOT_BITS    (SLOT_BITS),
    .MAX_ATTEMPTS (MAX_ATTEMPTS)
  ) dpI (
    .clk            (clk),
    .rstN           (rstN),
    .bitTick        (bitTick),
    .txActive       (txActive),
    .stb            (stb),
    .slotOver       (slotOver),
    .lastAttempt    (lastAttempt),
    .holdData       (holdData),
    .attemptCnt     (attemptCnt),
    .statusValid    (statusValid),
    .statusOk       (statusOk),
    .statusRetryErr (statusRetryErr),
    .statusLateCol  (statusLateCol),
    .ownRelease     (ownRelease)
  );

  assign restartTx = stb.restartAttempt;
endmodule

// File: rtl/txCollisionRetryChk.sv
module txCollisionRetryChk #(
  parameter int MAX_ATTEMPTS = 16
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              txActive,
  input logic                              restartTx,
  input logic                              holdData,
  input logic [$clog2(MAX_ATTEMPTS+1)-1:0] attemptCnt,
  input logic                              statusValid,
  input logic                              statusOk,
  input logic                              statusRetryErr,
  input logic                              statusLateCol,
  input logic                              skipClear
);
  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);

  p_one_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> $countones({statusOk, statusRetryErr, statusLateCol}) == 1);

  p_flags_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !statusValid |-> !(statusOk || statusRetryErr || statusLateCol));

  p_status_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid);

  p_restart_bump_r3: assert property (@(posedge clk) disable iff (!rstN)
    restartTx |=> txActive && (attemptCnt == ATT_W'($past(attemptCnt) + 1'b1)));

  p_late_no_retry_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusLateCol |-> !txActive);

  p_attempt_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    attemptCnt <= ATT_W'(MAX_ATTEMPTS));

  p_hold_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    holdData |-> txActive);

  p_skip_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    skipClear |-> !txActive);
endmodule

bind txCollisionRetry txCollisionRetryChk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) chkI (
  .clk            (clk),
  .rstN           (rstN),
  .txActive       (txActive),
  .restartTx      (restartTx),
  .holdData       (holdData),
  .attemptCnt     (attemptCnt),
  .statusValid    (statusValid),
  .statusOk       (statusOk),
  .statusRetryErr (statusRetryErr),
  .statusLateCol  (statusLateCol),
  .skipClear      (skipClear)
);

// File: tb/txCollisionRetry_tb_top.sv
`timescale 1ns/100ps
module txCollisionRetry_tb_top;
  localparam int SLOT = 512;
  localparam int MAXA = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txStart = 0, bitTick = 0, collision = 0, txDone = 0;
  logic backoffDone = 0, descStrobe = 0, descSop = 0;
  logic txActive, restartTx, holdData, statusValid, statusOk;
  logic statusRetryErr, statusLateCol, ownRelease, skipClear;
  logic [4:0] attemptCnt;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  txCollisionRetry dut_i (
    .clk(clk), .rstN(rstN), .txStart(txStart), .bitTick(bitTick),
    .collision(collision), .txDone(txDone), .backoffDone(backoffDone),
    .descStrobe(descStrobe), .descSop(descSop), .txActive(txActive),
    .restartTx(restartTx), .holdData(holdData), .attemptCnt(attemptCnt),
    .statusValid(statusValid), .statusOk(statusOk),
    .statusRetryErr(statusRetryErr), .statusLateCol(statusLateCol),
    .ownRelease(ownRelease), .skipClear(skipClear)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // 0 ok, 1 retry exhausted, 2 late collision
  function automatic int expKind(input int nEarly, input int endKind);
    if (nEarly >= MAXA) return 1;
    if (endKind == 1)   return 2;
    return 0;
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      cyc();
    end
    bitTick = 1'b0;
  endtask

  task automatic checkStatus(input int kind, input string req);
    chk({req, " statusValid"}, statusValid, 1);
    chk({req, " ownRelease"}, ownRelease, 1);
    chk({req, " flags"}, {statusOk, statusRetryErr, statusLateCol},
        kind == 0 ? 3'b100 : (kind == 1 ? 3'b010 : 3'b001));
    chk({req, " no retry after end"}, txActive, 0);
    cyc();
    chk("R8 status pulse one cycle", statusValid, 0);
    chk("R8 flags clear", {statusOk, statusRetryErr, statusLateCol}, 0);
  endtask

  task automatic skipPhase(input int nSkip);
    for (int i = 0; i < nSkip; i++) begin
      descStrobe = 1'b1; descSop = 1'b0;
      #1 chk("R9 skipClear on follow-on", skipClear, 1);
      cyc();
    end
    descStrobe = 1'b0;
    txStart = 1'b1;
    cyc();
    txStart = 1'b0;
    chk("R9 txStart ignored while skipping", txActive, 0);
    descStrobe = 1'b1; descSop = 1'b1;
    #1 chk("R9 no clear on sop", skipClear, 0);
    cyc();
    descStrobe = 1'b0; descSop = 1'b0;
    chk("R9 idle after sop", txActive, 0);
  endtask

  task automatic startFrame();
    txStart = 1'b1;
    cyc();
    txStart = 1'b0;
    chk("R2 txActive after start", txActive, 1);
    chk("R12 attempt count restarts at 1", attemptCnt, 1);
  endtask

  task automatic backoff(input int expNext);
    repeat ($urandom_range(0, 4)) cyc();
    backoffDone = 1'b1;
    #1 chk("R3 restartTx with backoffDone", restartTx, 1);
    cyc();
    backoffDone = 1'b0;
    chk("R3 active after backoff", txActive, 1);
    chk("R3 attempt incremented", attemptCnt, expNext);
  endtask

  task automatic runFrame(input int nEarly, input int endKind, input int finalTicks,
                          input int earlyTicks, input int nSkip);
    int kind;
    kind = expKind(nEarly, endKind);
    startFrame();
    for (int a = 1; a <= MAXA; a++) begin
      if (a <= nEarly) begin
        ticks(earlyTicks >= 0 ? earlyTicks : $urandom_range(0, 40));
        chk("R4 hold inside slot", holdData, 1);
        collision = 1'b1;
        cyc();
        collision = 1'b0;
        if (a == MAXA) begin
          checkStatus(kind, "R6");
          break;
        end
        chk("R3 no status on early collision", statusValid, 0);
        chk("R3 idle during backoff", txActive, 0);
        backoff(a + 1);
      end else begin
        ticks(finalTicks);
        chk("R4 hold vs slot", holdData, finalTicks < SLOT ? 1 : 0);
        if (endKind == 0) txDone = 1'b1;
        else              collision = 1'b1;
        cyc();
        txDone = 1'b0; collision = 1'b0;
        checkStatus(kind, kind == 0 ? "R7" : "R5");
        break;
      end
    end
    if (kind != 0) skipPhase(nSkip);
    else chk("R7 idle after success", txActive, 0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) cyc();
    chk("R1 txActive", txActive, 0);
    chk("R1 status", {statusValid, ownRelease, statusOk, statusRetryErr, statusLateCol}, 0);
    chk("R1 attemptCnt", attemptCnt, 0);
    chk("R1 hold/strobes", {holdData, restartTx, skipClear}, 0);
    rstN = 1'b1;
    cyc();

    runFrame(0, 0, 10, -1, 0);
    runFrame(1, 0, 5, SLOT - 1, 0);      // boundary: early at SLOT-1
    runFrame(0, 1, SLOT, -1, 2);         // boundary: late at exactly SLOT
    runFrame(MAXA, 0, 0, -1, 3);         // exhaustion
    runFrame(MAXA - 1, 0, 3, -1, 0);     // last allowed attempt succeeds

    // R10: collision and txDone together
    startFrame();
    ticks(5);
    collision = 1'b1; txDone = 1'b1;
    cyc();
    collision = 1'b0; txDone = 1'b0;
    chk("R10 collision wins over done", statusValid, 0);
    chk("R10 in backoff", txActive, 0);
    backoff(2);
    txDone = 1'b1; cyc(); txDone = 1'b0;
    checkStatus(0, "R10");

    // R11: stray txStart and backoffDone mid-frame
    startFrame();
    ticks(3);
    txStart = 1'b1; cyc(); txStart = 1'b0;
    backoffDone = 1'b1;
    #1 chk("R11 no restart outside backoff", restartTx, 0);
    cyc(); backoffDone = 1'b0;
    chk("R11 attempt unchanged", attemptCnt, 1);
    chk("R11 still active", txActive, 1);
    chk("R11 no status", statusValid, 0);
    txDone = 1'b1; cyc(); txDone = 1'b0;
    checkStatus(0, "R11");

    for (int f = 0; f < 25; f++) begin
      int ne, ek, ft;
      ne = ($urandom_range(0, 3) == 0) ? MAXA : $urandom_range(0, 6);
      ek = $urandom_range(0, 1);
      ft = (ek == 1) ? SLOT + $urandom_range(0, 20)
                     : (($urandom_range(0, 3) == 0) ? SLOT + 8 : $urandom_range(0, 40));
      runFrame(ne, ek, ft, -1, $urandom_range(0, 3));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule